// File: doc/BRIEF.md
# Digital Frequency-Locked Oscillator Trimmer

This block keeps a local oscillator on frequency while the chip runs. It runs entirely on the oscillator clock. It counts oscillator cycles over each period of a slower, more accurate reference and compares that count with a programmable target ratio. After each measurement it moves a calibration code one step up or down, which drives the trim input of the analog oscillator. The oscillator itself is outside the block.

One of four reference sources is picked by a select input. Three of them are continuous clocks: an internal 32.768 kHz oscillator, a 32.768 kHz crystal and an external clock. These are divided by 32 to give windows of roughly 1.024 kHz. The fourth is a start-of-frame pulse that already arrives about once per millisecond, so it skips the divider. The chosen reference is brought into the oscillator domain through a two-flop synchronizer before its rising edges are detected.

A small write port loads the target ratio and the calibration code. Software must preload a sensible calibration code before it enables the loop with the start-of-frame reference. A lock flag reports that the loop has settled.

Top module: `osc_trim_loop`

## Requirements
- R1: After reset, `cal_code` equals parameter CAL_RST (64 by default), `locked` is 0 and the target ratio register holds parameter COMP_RST.
- R2: The `ref_sel` encoding is 0 = internal 32.768 kHz oscillator, 1 = crystal, 2 = external clock. With a clock reference selected, one measurement window spans PRESCALE (32) rising edges of the synchronized reference.
- R3: With `ref_sel` = 3 (start-of-frame), every synchronized rising edge of `ref_sof` closes a window, with no division.
- R4: The first window boundary after `loop_en` rises only restarts the count and does not change `cal_code` or the lock state.
- R5: At each later window boundary the window length N (oscillator cycles between boundaries) is compared with the target. N greater than the target decrements `cal_code` by 1, N smaller increments it by 1, and N equal leaves it unchanged.
- R6: `cal_code` saturates at 0 and at 2^CAL_W-1 and never wraps.
- R7: `locked` rises after LOCK_WINDOWS (3) consecutive measured windows with N within ±1 of the target. Any window outside that band clears it, and `loop_en` low clears it on the next cycle.
- R8: A write with `wr_addr` = 0 loads `wr_data` into the target ratio at any time, and the new target is used for later windows.
- R9: A write with `wr_addr` = 1 loads `wr_data[CAL_W-1:0]` into `cal_code`, visible on the next cycle, only while `loop_en` is 0. While the loop is enabled such writes are ignored.
- R10: While `loop_en` is 0, reference edges do not change `cal_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock being trimmed |
| osc_rst_n | input | 1 | Active-low reset, synchronous to osc_clk |
| ref_int_osc | input | 1 | Internal 32.768 kHz reference clock |
| ref_xtal | input | 1 | Crystal 32.768 kHz reference clock |
| ref_ext | input | 1 | External reference clock |
| ref_sof | input | 1 | Start-of-frame pulse reference |
| ref_sel | input | 2 | Reference choice (0 int, 1 crystal, 2 external, 3 start-of-frame) |
| loop_en | input | 1 | Closes the trim loop when high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = target ratio, 1 = calibration code |
| wr_data | input | CNT_W | Write data |
| cal_code | output | CAL_W | Calibration code to the oscillator |
| locked | output | 1 | Loop settled within ±1 of the target |

## Verification
The bench drives start-of-frame edges at exact spacings, so each window length is known to the cycle. It walks a sequence of lengths above, below, at, and one off the target. A design that included the partial window after enable would step the code at once. An off-by-one in the window counter would shift every decision and the lock band. The code is pushed against both rails, where a wrapping design would jump from 127 to 0 or back. Calibration writes are issued while the loop runs, and edges are sent while it is off; in both cases `cal_code` must not move. Each clock reference is run at a ratio equal to the target, which only holds steady and locks if the divide-by-32 is applied, and a mismatched target must make the code fall.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

    typedef enum logic [1:0] {
        REF_INT_OSC = 2'd0,
        REF_XTAL    = 2'd1,
        REF_EXT     = 2'd2,
        REF_SOF     = 2'd3
    } ref_src_e;

    localparam logic WR_ADDR_COMP = 1'b0;
    localparam logic WR_ADDR_CAL  = 1'b1;

endpackage

// File: rtl/trim_ref_select.sv
module trim_ref_select
    import osc_trim_pkg::*;
#(
    parameter int PRESCALE    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       ref_int_osc,
    input  logic       ref_xtal,
    input  logic       ref_ext,
    input  logic       ref_sof,
    input  logic [1:0] ref_sel,
    output logic       win_tick
);

    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic [PRE_W-1:0]       pre_cnt;
    } sel_state_t;

    sel_state_t s_d, s_q;
    logic raw_ref;
    logic ref_rise;
    logic bypass;
    logic pre_wrap;

    // Reference multiplexer (before the synchronizer)
    always_comb begin
        case (ref_src_e'(ref_sel))
            REF_INT_OSC: raw_ref = ref_int_osc;
            REF_XTAL:    raw_ref = ref_xtal;
            REF_EXT:     raw_ref = ref_ext;
            default:     raw_ref = ref_sof;
        endcase
    end

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[SYNC_STAGES-2:0], raw_ref};
        s_d.prev = s_q.sync[SYNC_STAGES-1];

        ref_rise = s_q.sync[SYNC_STAGES-1] & ~s_q.prev;
        bypass   = (ref_src_e'(ref_sel) == REF_SOF);
        pre_wrap = (s_q.pre_cnt == PRE_LAST);
        win_tick = run & ref_rise & (bypass | pre_wrap);

        if (!run || bypass) begin
            s_d.pre_cnt = '0;
        end else if (ref_rise) begin
            s_d.pre_cnt = pre_wrap ? '0 : s_q.pre_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/trim_window_counter.sv
module trim_window_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             win_tick,
    output logic             meas_valid,
    output logic [CNT_W-1:0] meas_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             primed;
    } win_state_t;

    win_state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        meas_count = (s_q.cnt == CNT_MAX) ? CNT_MAX : s_q.cnt + 1'b1;
        meas_valid = run & win_tick & s_q.primed;

        if (!run) begin
            s_d.cnt    = '0;
            s_d.primed = 1'b0;
        end else if (win_tick) begin
            s_d.cnt    = '0;
            s_d.primed = 1'b1;
        end else if (s_q.cnt != CNT_MAX) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/trim_cal_ctrl.sv
module trim_cal_ctrl
    import osc_trim_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int CAL_W        = 7,
    parameter int COMP_RST     = 31250,
    parameter int CAL_RST      = 64,
    parameter int LOCK_WINDOWS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             meas_valid,
    input  logic [CNT_W-1:0] meas_count,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CAL_W-1:0] cal_code,
    output logic             locked
);

    localparam int STREAK_W = $clog2(LOCK_WINDOWS + 1);
    localparam logic [STREAK_W-1:0] STREAK_FULL = STREAK_W'(LOCK_WINDOWS);
    localparam logic [CAL_W-1:0]    CAL_MAX     = {CAL_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0]    comp;
        logic [CAL_W-1:0]    cal;
        logic [STREAK_W-1:0] streak;
    } cal_state_t;

    cal_state_t s_d, s_q;
    logic [CNT_W:0] m_ext, c_ext;
    logic too_slow, too_fast, near;

    always_comb begin
        s_d   = s_q;
        m_ext = {1'b0, meas_count};
        c_ext = {1'b0, s_q.comp};

        too_fast = m_ext > c_ext;
        too_slow = m_ext < c_ext;
        near     = (m_ext <= c_ext + 1'b1) && (m_ext + 1'b1 >= c_ext);

        if (wr_en && wr_addr == WR_ADDR_COMP) begin
            s_d.comp = wr_data;
        end

        if (run) begin
            if (meas_valid) begin
                if (too_fast && s_q.cal != '0) begin
                    s_d.cal = s_q.cal - 1'b1;
                end else if (too_slow && s_q.cal != CAL_MAX) begin
                    s_d.cal = s_q.cal + 1'b1;
                end
                if (!near) begin
                    s_d.streak = '0;
                end else if (s_q.streak != STREAK_FULL) begin
                    s_d.streak = s_q.streak + 1'b1;
                end
            end
        end else begin
            s_d.streak = '0;
            if (wr_en && wr_addr == WR_ADDR_CAL) begin
                s_d.cal = wr_data[CAL_W-1:0];
            end
        end

        cal_code = s_q.cal;
        locked   = (s_q.streak == STREAK_FULL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.comp   <= CNT_W'(COMP_RST);
            s_q.cal    <= CAL_W'(CAL_RST);
            s_q.streak <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/osc_trim_loop.sv
module osc_trim_loop #(
    parameter int PRESCALE     = 32,
    parameter int CNT_W        = 16,
    parameter int CAL_W        = 7,
    parameter int COMP_RST     = 31250,
    parameter int CAL_RST      = 64,
    parameter int LOCK_WINDOWS = 3
) (
    input  logic             osc_clk,
    input  logic             osc_rst_n,
    input  logic             ref_int_osc,
    input  logic             ref_xtal,
    input  logic             ref_ext,
    input  logic             ref_sof,
    input  logic [1:0]       ref_sel,
    input  logic             loop_en,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CAL_W-1:0] cal_code,
    output logic             locked
);

    logic             win_tick;
    logic             meas_valid;
    logic [CNT_W-1:0] meas_count;

    trim_ref_select #(
        .PRESCALE    (PRESCALE),
        .SYNC_STAGES (2)
    ) u_ref (
        .clk         (osc_clk),
        .rst_n       (osc_rst_n),
        .run         (loop_en),
        .ref_int_osc (ref_int_osc),
        .ref_xtal    (ref_xtal),
        .ref_ext     (ref_ext),
        .ref_sof     (ref_sof),
        .ref_sel     (ref_sel),
        .win_tick    (win_tick)
    );

    trim_window_counter #(
        .CNT_W (CNT_W)
    ) u_win (
        .clk        (osc_clk),
        .rst_n      (osc_rst_n),
        .run        (loop_en),
        .win_tick   (win_tick),
        .meas_valid (meas_valid),
        .meas_count (meas_count)
    );

    trim_cal_ctrl #(
        .CNT_W        (CNT_W),
        .CAL_W        (CAL_W),
        .COMP_RST     (COMP_RST),
        .CAL_RST      (CAL_RST),
        .LOCK_WINDOWS (LOCK_WINDOWS)
    ) u_cal (
        .clk        (osc_clk),
        .rst_n      (osc_rst_n),
        .run        (loop_en),
        .meas_valid (meas_valid),
        .meas_count (meas_count),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cal_code   (cal_code),
        .locked     (locked)
    );

endmodule

// File: rtl/osc_trim_checker.sv
module osc_trim_checker #(
    parameter int CAL_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             loop_en,
    input logic             wr_en,
    input logic             wr_addr,
    input logic             meas_valid,
    input logic [CAL_W-1:0] cal_code,
    input logic             locked
);

    // R5 / R6: while running, the code moves by at most one step, never wraps
    assert_cal_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(loop_en) |->
            ({1'b0, cal_code} == {1'b0, $past(cal_code)}) ||
            ({1'b0, cal_code} == {1'b0, $past(cal_code)} + 1'b1) ||
            ({1'b0, cal_code} == {1'b0, $past(cal_code)} - 1'b1))
        else $error("cal_code stepped by more than one");

    // R5 / R9: while running, the code changes only after a measured window
    assert_cal_only_on_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(loop_en) && !$past(meas_valid)) |-> $stable(cal_code))
        else $error("cal_code moved without a window");

    // R10: with the loop off and no calibration write, the code holds
    assert_hold_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(loop_en) && !($past(wr_en) && $past(wr_addr))) |-> $stable(cal_code))
        else $error("cal_code moved while loop off");

    // R7: disabling clears lock on the next cycle
    assert_lock_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en |=> !locked)
        else $error("locked held while disabled");

    // R7: lock can only be gained right after a measured window
    assert_lock_on_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(meas_valid))
        else $error("lock rose without a window");

    // R4: no measurement is produced while the loop is off
    assert_meas_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |-> loop_en)
        else $error("measurement while disabled");

endmodule

bind osc_trim_loop osc_trim_checker #(.CAL_W(CAL_W)) u_chk (
    .clk        (osc_clk),
    .rst_n      (osc_rst_n),
    .loop_en    (loop_en),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .meas_valid (meas_valid),
    .cal_code   (cal_code),
    .locked     (locked)
);

// File: tb/sim_osc_trim_loop.sv
module sim_osc_trim_loop;

    localparam int CNT_W = 16;
    localparam int CAL_W = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_int_osc = 1'b0, ref_xtal = 1'b0, ref_ext = 1'b0, ref_sof = 1'b0;
    logic [1:0]       ref_sel = 2'd3;
    logic             loop_en = 1'b0;
    logic             wr_en = 1'b0;
    logic             wr_addr = 1'b0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [CAL_W-1:0] cal_code;
    logic             locked;

    int errors = 0;
    int checks = 0;
    int since  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    osc_trim_loop #(
        .PRESCALE (32), .CNT_W (CNT_W), .CAL_W (CAL_W),
        .COMP_RST (100), .CAL_RST (64), .LOCK_WINDOWS (3)
    ) u0 (
        .osc_clk (clk), .osc_rst_n (rst_n),
        .ref_int_osc (ref_int_osc), .ref_xtal (ref_xtal), .ref_ext (ref_ext),
        .ref_sof (ref_sof), .ref_sel (ref_sel), .loop_en (loop_en),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .cal_code (cal_code), .locked (locked)
    );

    // Reference clocks: half periods of 2, 3 and 1 oscillator cycles
    int c_int = 0, c_xt = 0;
    always @(negedge clk) begin
        ref_ext <= ~ref_ext;
        if (c_int == 1) begin c_int <= 0; ref_int_osc <= ~ref_int_osc; end
        else c_int <= c_int + 1;
        if (c_xt == 2) begin c_xt <= 0; ref_xtal <= ~ref_xtal; end
        else c_xt <= c_xt + 1;
    end

    typedef struct packed {
        logic [15:0] gap;
        logic [6:0]  cal;
        logic        lock;
    } vec_t;

    // Target 100 (reset value): window length, expected code, expected lock
    localparam vec_t VECS [10] = '{
        '{16'd100, 7'd64, 1'b0},
        '{16'd101, 7'd63, 1'b0},
        '{16'd99,  7'd64, 1'b1},
        '{16'd110, 7'd63, 1'b0},
        '{16'd90,  7'd64, 1'b0},
        '{16'd90,  7'd65, 1'b0},
        '{16'd100, 7'd65, 1'b0},
        '{16'd100, 7'd65, 1'b0},
        '{16'd100, 7'd65, 1'b1},
        '{16'd102, 7'd64, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        since += n;
    endtask

    // Start-of-frame edge placed gap cycles after the previous one, then 6 cycles to settle
    task automatic window(input int gap);
        step(gap - since);
        ref_sof = 1'b1;
        step(1);
        ref_sof = 1'b0;
        since = 1;
        step(5);
    endtask

    task automatic wr(input logic a, input int d);
        wr_en = 1'b1; wr_addr = a; wr_data = CNT_W'(d);
        step(1);
        wr_en = 1'b0;
        step(1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        step(4);
        chk("R1 cal reset", int'(cal_code), 64);
        chk("R1 lock reset", int'(locked), 0);
        rst_n = 1'b1;
        step(2);

        // SOF reference, priming edge must not move the code (R4)
        ref_sel = 2'd3;
        loop_en = 1'b1;
        step(3);
        window(40);
        chk("R4 first window discarded", int'(cal_code), 64);

        // Vector walk: R1 default target, R3 bypass, R5 steps, R7 lock
        for (int i = 0; i < 10; i++) begin
            window(int'(VECS[i].gap));
            chk($sformatf("R5/R3 vec %0d cal", i), int'(cal_code), int'(VECS[i].cal));
            chk($sformatf("R7 vec %0d lock", i), int'(locked), int'(VECS[i].lock));
        end

        // R9: calibration write ignored while running
        wr(1'b1, 10);
        chk("R9 write ignored when enabled", int'(cal_code), 64);

        // R8: new target takes effect
        wr(1'b0, 50);
        window(50);
        chk("R8 new target equal holds", int'(cal_code), 64);
        window(60);
        chk("R8 new target above decrements", int'(cal_code), 63);

        // R6 upper rail
        loop_en = 1'b0;
        wr(1'b1, 127);
        chk("R9 direct write when disabled", int'(cal_code), 127);
        loop_en = 1'b1;
        window(60);
        window(40);
        chk("R6 saturate at max", int'(cal_code), 127);
        window(40);
        chk("R6 stays at max", int'(cal_code), 127);

        // R6 lower rail
        loop_en = 1'b0;
        wr(1'b1, 0);
        chk("R9 direct write zero", int'(cal_code), 0);
        loop_en = 1'b1;
        window(60);
        window(70);
        chk("R6 saturate at zero", int'(cal_code), 0);
        window(50);
        window(50);
        chk("R7 not locked after two", int'(locked), 0);
        window(50);
        chk("R7 locked after three", int'(locked), 1);

        // R7 / R10: disable clears lock, edges ignored
        loop_en = 1'b0;
        step(2);
        chk("R7 lock cleared by disable", int'(locked), 0);
        window(30);
        window(30);
        chk("R10 code holds while disabled", int'(cal_code), 0);

        // R2: clock references through divide-by-32
        wr(1'b1, 64);
        ref_sel = 2'd0;
        wr(1'b0, 128);
        loop_en = 1'b1;
        step(128 * 6);
        chk("R2 int osc ratio 128 holds", int'(cal_code), 64);
        chk("R2 int osc locks", int'(locked), 1);

        loop_en = 1'b0;
        ref_sel = 2'd1;
        wr(1'b0, 192);
        loop_en = 1'b1;
        step(192 * 6);
        chk("R2 crystal ratio 192 holds", int'(cal_code), 64);
        chk("R2 crystal locks", int'(locked), 1);

        loop_en = 1'b0;
        ref_sel = 2'd2;
        wr(1'b0, 64);
        loop_en = 1'b1;
        step(64 * 6);
        chk("R2 external ratio 64 holds", int'(cal_code), 64);
        chk("R2 external locks", int'(locked), 1);

        loop_en = 1'b0;
        ref_sel = 2'd0;
        wr(1'b0, 100);
        loop_en = 1'b1;
        step(128 * 6);
        chk("R2 fast ratio lowers code", int'(cal_code < 7'd62), 1);
        chk("R2 fast ratio not locked", int'(locked), 0);

        finish_run();
    end

endmodule